// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps a 12-hour wall-clock time in four byte-wide BCD fields: tenths of a second, seconds, minutes and hours. The hours byte also carries an afternoon flag. A one-cycle `tick` pulse, produced elsewhere from the mains-derived tenth-of-second timebase, advances the time by one tenth. Carries ripple upward through the fields, and the afternoon flag is handled at the 11-to-12 rollover.

Software sees the time through a small byte port. Setting the time begins with the hours byte, which halts counting, and ends with the tenths byte, which resumes it. Reading the time begins with the hours byte, which freezes a coherent snapshot, and ends with the tenths byte, which releases it. A select input sends writes to a second set of four alarm registers instead. Whenever a tick or a write changes either register set and the two sets match exactly, the block emits a one-cycle `alarm_evt` pulse toward the interrupt logic.

Top module: `tod_clock`

## Requirements
- R1: After reset the time reads 12:00:00.0 AM (hours 0x12, the rest 0x00), the alarm registers are all 0x00, the clock runs, and no snapshot is held.
- R2: Each accepted `tick` adds one tenth. Tenths wrap 9 to 0 with a carry into seconds, seconds wrap 0x59 to 0x00 with a carry into minutes, and minutes wrap 0x59 to 0x00 with a carry into hours.
- R3: A clock write to hours stops counting, so later ticks are ignored. A clock write to tenths restarts counting. A tick in the same cycle as a clock write is ignored.
- R4: Hours wrap 0x11 to 0x12 with the afternoon flag (hours bit 7) inverted, and 0x12 to 0x01 with the flag kept.
- R5: Reading hours while no snapshot is held captures all four fields. Later reads return the snapshot until tenths is read, which returns the snapshot tenths and releases it. Counting continues throughout.
- R6: Write data is masked per field: tenths keep bits 3:0, seconds and minutes keep bits 6:0, and hours keep bits 7 and 4:0. A masked hours value whose bits 4:0 equal 0x12 has bit 7 inverted.
- R7: With `alarm_sel` = 1 a write updates the alarm register at `addr`. The clock fields and the run/stop state are left unchanged.
- R8: `alarm_evt` is high for exactly the cycle after a cycle in which a tick or any write updated a register set, provided all four clock fields then equal the four alarm fields.
- R9: `addr` selects 0 = tenths, 1 = seconds, 2 = minutes, 3 = hours. `rdata` is registered: it updates on the edge that samples `rd_en` and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Tenth-of-second advance pulse |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| alarm_sel | input | 1 | 1 = writes target the alarm registers |
| addr | input | 2 | Field select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| alarm_evt | output | 1 | One-cycle alarm match pulse |

## Verification
A tick or write that is sampled at edge N updates the registers at edge N. The matching `alarm_evt` pulse follows at edge N+1, so it appears one cycle after the register change. Read data sampled at edge N is valid just after edge N. The bench drives inputs on falling edges. A monitor samples two nanoseconds after each rising edge: on that edge it compares `rdata` against the value queued by the read task, and it counts alarm pulses there. One alarm tick is followed edge by edge to show the pulse absent, present, then absent.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int FIELDS = 4;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = $clog2(FIELDS);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [FIELDS-1:0][BYTE_W-1:0] tod_t;

  localparam logic [ADDR_W-1:0] F_TENTH = 2'd0;
  localparam logic [ADDR_W-1:0] F_SEC   = 2'd1;
  localparam logic [ADDR_W-1:0] F_MIN   = 2'd2;
  localparam logic [ADDR_W-1:0] F_HOUR  = 2'd3;

  // One BCD increment of a two-digit value (no wrap handling)
  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Field masking applied to every write, clock or alarm
  function automatic byte_t wr_filter(input logic [ADDR_W-1:0] f, input byte_t d);
    byte_t h;
    case (f)
      F_TENTH: return d & 8'h0F;
      F_SEC,
      F_MIN:   return d & 8'h7F;
      default: begin
        h = d & 8'h9F;
        if (h[4:0] == 5'h12) h[7] = ~h[7];
        return h;
      end
    endcase
  endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter byte_t RST_HOUR = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  output tod_t              cur,
  output logic              stopped,
  output logic              upd
);
  tod_t nxt;
  logic carry;
  byte_t hinc;

  always_comb begin
    nxt   = cur;
    carry = 1'b0;
    hinc  = bcd_inc({3'b000, cur[F_HOUR][4:0]});
    if (cur[F_TENTH] == 8'h09) begin
      nxt[F_TENTH] = 8'h00;
      carry = 1'b1;
    end else begin
      nxt[F_TENTH] = bcd_inc(cur[F_TENTH]);
    end
    for (int i = 1; i < FIELDS - 1; i++) begin
      if (carry) begin
        if (cur[i] == 8'h59) begin
          nxt[i] = 8'h00;
        end else begin
          nxt[i] = bcd_inc(cur[i]);
          carry  = 1'b0;
        end
      end
    end
    if (carry) begin
      if (cur[F_HOUR][4:0] == 5'h11)
        nxt[F_HOUR] = {~cur[F_HOUR][7], 2'b00, 5'h12};
      else if (cur[F_HOUR][4:0] == 5'h12)
        nxt[F_HOUR] = {cur[F_HOUR][7], 2'b00, 5'h01};
      else
        nxt[F_HOUR] = {cur[F_HOUR][7], 2'b00, hinc[4:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= {RST_HOUR, 8'h00, 8'h00, 8'h00};
      stopped <= 1'b0;
      upd     <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (wr_en) begin
        cur[addr] <= wdata;
        upd       <= 1'b1;
        if (addr == F_HOUR)  stopped <= 1'b1;
        if (addr == F_TENTH) stopped <= 1'b0;
      end else if (tick && !stopped) begin
        cur <= nxt;
        upd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  tod_t              cur,
  input  logic              cur_upd,
  output tod_t              alm,
  output logic              alarm_evt
);
  logic alm_upd;
  logic same;

  always_comb begin
    same = 1'b1;
    for (int i = 0; i < FIELDS; i++)
      if (cur[i] != alm[i]) same = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm       <= '0;
      alm_upd   <= 1'b0;
      alarm_evt <= 1'b0;
    end else begin
      alm_upd   <= wr_en;
      if (wr_en) alm[addr] <= wdata;
      alarm_evt <= (cur_upd || alm_upd) && same;
    end
  end
endmodule

// File: rtl/tod_rdport.sv
module tod_rdport
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  tod_t              cur,
  output tod_t              snap,
  output logic              latched,
  output byte_t             rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      latched <= 1'b0;
      rdata   <= '0;
    end else if (rd_en) begin
      rdata <= latched ? snap[addr] : cur[addr];
      if (addr == F_HOUR && !latched) begin
        snap    <= cur;
        latched <= 1'b1;
      end
      if (addr == F_TENTH) latched <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter logic [7:0] RST_HOUR = 8'h12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       alarm_sel,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_evt
);
  byte_t wfilt;
  logic  wr_clk, wr_alm;
  tod_t  cur_tod, alm_tod, snap_tod;
  logic  stopped, cur_upd, latched;

  assign wfilt  = wr_filter(addr, wdata);
  assign wr_clk = wr_en && !alarm_sel;
  assign wr_alm = wr_en && alarm_sel;

  tod_counter #(.RST_HOUR(RST_HOUR)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_clk), .addr(addr),
    .wdata(wfilt), .cur(cur_tod), .stopped(stopped), .upd(cur_upd)
  );

  tod_alarm u_alm (
    .clk(clk), .rst(rst), .wr_en(wr_alm), .addr(addr), .wdata(wfilt),
    .cur(cur_tod), .cur_upd(cur_upd), .alm(alm_tod), .alarm_evt(alarm_evt)
  );

  tod_rdport u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cur(cur_tod),
    .snap(snap_tod), .latched(latched), .rdata(rdata)
  );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
  import tod_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic       alarm_evt,
  input logic       wr_clk,
  input logic       wr_alm,
  input logic       stopped,
  input logic       latched,
  input tod_t       cur_tod,
  input tod_t       alm_tod,
  input tod_t       snap_tod
);
  assert_tenth_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_tod[0] == 8'h09 && tick && !stopped && !wr_clk) |=> (cur_tod[0] == 8'h00));

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (stopped && !wr_clk) |=> $stable(cur_tod));

  assert_snap_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (latched && !(rd_en && addr == 2'd0)) |=> $stable(snap_tod));

  assert_alarm_no_stop_R7: assert property (@(posedge clk) disable iff (rst)
    wr_alm |=> $stable(stopped));

  assert_evt_match_R8: assert property (@(posedge clk) disable iff (rst)
    alarm_evt |-> $past(cur_tod == alm_tod));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .alarm_evt(alarm_evt), .wr_clk(wr_clk), .wr_alm(wr_alm),
  .stopped(stopped), .latched(latched), .cur_tod(cur_tod),
  .alm_tod(alm_tod), .snap_tod(snap_tod)
);

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, alarm_sel = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       alarm_evt;

  int tests = 0, fails = 0, evt_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tod_clock dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .alarm_sel(alarm_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_evt(alarm_evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data and counts alarm pulses after each rising edge
  initial begin
    forever begin
      logic fire;
      @(posedge clk);
      fire = rd_en;
      #2;
      if (alarm_evt) evt_cnt++;
      if (fire && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'h0, rdata}, {24'h0, e});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; alarm_sel = sel;
    @(negedge clk);
    wr_en = 1'b0; alarm_sel = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input logic [7:0] h, input logic [7:0] m,
                        input logic [7:0] s, input logic [7:0] t, input string tag);
    rd(2'd3, h, {tag, " hours"});
    rd(2'd2, m, {tag, " minutes"});
    rd(2'd1, s, {tag, " seconds"});
    rd(2'd0, t, {tag, " tenths"});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_all(8'h12, 8'h00, 8'h00, 8'h00, "R1 reset");
    repeat (3) @(negedge clk);
    check("R9 rdata holds after last read", {24'h0, rdata}, 32'h0);
    check("R1 no alarm after reset", evt_cnt, 0);

    // R4 / R2: 11:59:59.9 AM -> 12:00:00.0 PM
    wr(2'd3, 8'h11, 1'b0);
    wr(2'd2, 8'h59, 1'b0);
    wr(2'd1, 8'h59, 1'b0);
    wr(2'd0, 8'h09, 1'b0);
    ticks(1);
    rd_all(8'h92, 8'h00, 8'h00, 8'h00, "R4 11 to 12 PM flip");

    // R2 tenths into seconds carry
    wr(2'd1, 8'h09, 1'b0);
    wr(2'd0, 8'h09, 1'b0);
    ticks(1);
    rd_all(8'h92, 8'h00, 8'h10, 8'h00, "R2 BCD carry");

    // R3 stop on hours write, restart on tenths write
    wr(2'd3, 8'h05, 1'b0);
    ticks(3);
    rd_all(8'h05, 8'h00, 8'h10, 8'h00, "R3 stopped ignores ticks");
    wr(2'd0, 8'h03, 1'b0);
    ticks(2);
    rd_all(8'h05, 8'h00, 8'h10, 8'h05, "R3 restarted");

    // R5 snapshot
    rd(2'd3, 8'h05, "R5 hours latch");
    ticks(6);
    rd(2'd1, 8'h10, "R5 seconds from snapshot");
    rd(2'd0, 8'h05, "R5 tenths from snapshot");
    rd(2'd1, 8'h11, "R5 seconds live after release");
    rd(2'd0, 8'h01, "R5 tenths live");

    // R6 masking and hour-12 inversion
    wr(2'd3, 8'hE3, 1'b0);
    rd_all(8'h83, 8'h00, 8'h11, 8'h01, "R6 hours mask");
    wr(2'd3, 8'h12, 1'b0);
    wr(2'd2, 8'hD9, 1'b0);
    wr(2'd1, 8'h59, 1'b0);
    wr(2'd0, 8'hF9, 1'b0);
    rd_all(8'h92, 8'h59, 8'h59, 8'h09, "R6 write masks");
    ticks(1);
    rd_all(8'h81, 8'h00, 8'h00, 8'h00, "R4 12 to 1 keeps PM");

    // R7 alarm writes leave the clock alone
    wr(2'd0, 8'h02, 1'b1);
    wr(2'd2, 8'h00, 1'b1);
    wr(2'd1, 8'h00, 1'b1);
    wr(2'd3, 8'h81, 1'b1);
    repeat (2) @(negedge clk);
    check("R8 no event without full match", evt_cnt, 0);
    rd_all(8'h81, 8'h00, 8'h00, 8'h00, "R7 clock unchanged");
    ticks(1);
    check("R8 no event at tenth 1", evt_cnt, 0);

    // R8 event timing: register change at edge N, pulse at N+1 only
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #2;
    check("R8 no pulse on update edge", {31'h0, alarm_evt}, 32'h0);
    @(negedge clk); tick = 1'b0;
    @(posedge clk); #2;
    check("R8 pulse one cycle after match", {31'h0, alarm_evt}, 32'h1);
    @(posedge clk); #2;
    check("R8 pulse lasts one cycle", {31'h0, alarm_evt}, 32'h0);
    check("R7 clock kept running after alarm write", evt_cnt, 1);
    ticks(1);
    check("R8 no event after match passes", evt_cnt, 1);

    // R8 write-triggered compare
    wr(2'd0, 8'h02, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 event on clock write match", evt_cnt, 2);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule